// File: doc/BRIEF.md
# Corner-Driven Bilinear Block Filler

This block completes square regions of a pixel canvas once the sampling logic has decided that a region needs no more samples. Each region is described by a work item holding its upper-left anchor and a size code `k`. The region side is `2^k + 1` pixels, so the four corner pixels sit `2^k` apart. The block takes one work item at a time from a shared queue and reads the four corners from the canvas. It then walks every position of the region and writes a bilinear blend of the corners into each position that is neither a corner nor already marked as a true sample.

The canvas has a read port with one cycle of latency. Each read returns the stored 8-bit gray value and that pixel's sampled flag. A write port takes filled values. The block writes only the positions it decides to fill and never touches the sampled flags. A trim input drops the far row and the far column of every region. This covers the case where those pixels were fetched only as support for the blend and belong to a neighbouring region.

Several copies may drain one queue. A copy asks for work only when it is idle. Arbitration of the pop requests between copies is handled outside the block.

Top module: `blk_bilerp`

## Requirements
- R1: During and right after synchronous reset, `busy`, `fifo_pop`, `rd_en` and `wr_en` are all low.
- R2: `fifo_pop` is high for exactly one cycle, only while `fifo_empty` is low and `busy` is low, and the descriptor on `desc_ax`/`desc_ay`/`desc_k` is taken in that cycle. Work items are processed in queue order.
- R3: In the first four cycles of `busy`, the block issues reads of the corners in the order top-left, top-right, bottom-left, bottom-right. With N = 2^k, these are at (ax,ay), (ax+N,ay), (ax,ay+N) and (ax+N,ay+N).
- R4: For a written position at offset (dx,dy) inside the region, the value is (TL·(N−dx)(N−dy) + TR·dx(N−dy) + BL·(N−dx)·dy + BR·dx·dy + N²/2) >> 2k, with k from 1 to 4.
- R5: A position whose read returns `rd_smp`=1 is never written.
- R6: The four corner positions are never written.
- R7: With `trim_far`=1, no position with dx=N or dy=N is written. With `trim_far`=0, those edge positions are filled like interior ones.
- R8: `busy` stays high for exactly 5 + (N+1)² cycles per work item, and every write falls inside that window.
- R9: The canvas address is y·DIM + x, and no position outside the region is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_empty | input | 1 | Work queue holds no item |
| fifo_pop | output | 1 | Take the item at the head of the queue |
| desc_ax | input | 5 | Region anchor column |
| desc_ay | input | 5 | Region anchor row |
| desc_k | input | 3 | Size code; side is 2^k+1 |
| trim_far | input | 1 | Skip the far row and far column of each region |
| rd_en | output | 1 | Canvas read request |
| rd_addr | output | 9 | Canvas read address |
| rd_data | input | 8 | Pixel value, one cycle after the request |
| rd_smp | input | 1 | Sampled flag of that pixel, same timing as rd_data |
| wr_en | output | 1 | Canvas write strobe |
| wr_addr | output | 9 | Canvas write address |
| wr_data | output | 8 | Filled pixel value |
| busy | output | 1 | A work item is in progress |

## Verification
The pop takes effect at the first clock edge where the block is idle and the queue is non-empty. `busy` and the first corner read appear in the cycle after that edge. The bench therefore waits for `busy` and records `rd_addr` on the first four falling edges where `busy` is high. It counts the falling edges with `busy` high and compares the count against 5 + (N+1)². A write lands one cycle after the read of its position, and the last write lands in the final busy cycle. For that reason the canvas and the write count are compared only two cycles after `busy` falls, against a model built from the requirement formula.

// File: rtl/blk_bilerp_pkg.sv
package blk_bilerp_pkg;

    parameter int unsigned BL_PIX_W = 8;

    typedef logic [BL_PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SCAN,
        ST_DRAIN
    } bl_state_e;

    // fetch order of the corners; the capture stage decodes it
    typedef enum logic [1:0] {
        CR_TL = 2'd0,
        CR_TR = 2'd1,
        CR_BL = 2'd2,
        CR_BR = 2'd3
    } corner_e;

    typedef struct packed {
        pix_t tl;
        pix_t tr;
        pix_t bl;
        pix_t br;
    } corner_set_t;

    function automatic logic bl_on_rim(int unsigned d, int unsigned n);
        return (d == 0) || (d == n);
    endfunction

endpackage

// File: rtl/blk_bilerp_ctrl.sv
module blk_bilerp_ctrl
    import blk_bilerp_pkg::*;
#(
    parameter int DIM     = 17,
    parameter int MAX_LOG = 4,
    localparam int COORD_W = $clog2(DIM),
    localparam int ADDR_W  = $clog2(DIM * DIM),
    localparam int KW      = $clog2(MAX_LOG + 1),
    localparam int OW      = MAX_LOG + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    input  logic [COORD_W-1:0] desc_ax,
    input  logic [COORD_W-1:0] desc_ay,
    input  logic [KW-1:0]     desc_k,
    input  logic              trim_far,
    output logic              busy,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cap_en,
    output logic [1:0]        cap_idx,
    output logic              s_v,
    output logic [OW-1:0]     s_dx,
    output logic [OW-1:0]     s_dy,
    output logic [ADDR_W-1:0] s_addr,
    output logic              s_keep,
    output logic [KW-1:0]     k_q
);

    bl_state_e state;
    logic [1:0]         cnt;
    logic [OW-1:0]      dx, dy, n, offx, offy;
    logic [COORD_W-1:0] ax_q, ay_q;
    logic               trim_q;
    logic               keep_now;

    always_comb begin
        n = OW'(1) << k_q;
        if (state == ST_FETCH) begin
            offx = cnt[0] ? n : '0;
            offy = cnt[1] ? n : '0;
        end else begin
            offx = dx;
            offy = dy;
        end
        rd_addr  = (ADDR_W'(ay_q) + ADDR_W'(offy)) * ADDR_W'(DIM)
                 + ADDR_W'(ax_q) + ADDR_W'(offx);
        rd_en    = (state == ST_FETCH) || (state == ST_SCAN);
        keep_now = !(bl_on_rim(int'(dx), int'(n)) && bl_on_rim(int'(dy), int'(n)))
                 && !(trim_q && ((dx == n) || (dy == n)));
        fifo_pop = (state == ST_IDLE) && !fifo_empty;
        busy     = (state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            dx      <= '0;
            dy      <= '0;
            ax_q    <= '0;
            ay_q    <= '0;
            k_q     <= '0;
            trim_q  <= 1'b0;
            cap_en  <= 1'b0;
            cap_idx <= '0;
            s_v     <= 1'b0;
            s_dx    <= '0;
            s_dy    <= '0;
            s_addr  <= '0;
            s_keep  <= 1'b0;
        end else begin
            cap_en  <= (state == ST_FETCH);
            cap_idx <= cnt;
            s_v     <= (state == ST_SCAN);
            s_dx    <= dx;
            s_dy    <= dy;
            s_addr  <= rd_addr;
            s_keep  <= keep_now;
            case (state)
                ST_IDLE: if (!fifo_empty) begin
                    ax_q   <= desc_ax;
                    ay_q   <= desc_ay;
                    k_q    <= desc_k;
                    trim_q <= trim_far;
                    cnt    <= '0;
                    state  <= ST_FETCH;
                end
                ST_FETCH: begin
                    cnt <= cnt + 2'd1;
                    if (cnt == 2'd3) begin
                        dx    <= '0;
                        dy    <= '0;
                        state <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (dx == n) begin
                        dx <= '0;
                        if (dy == n) begin
                            dy    <= '0;
                            state <= ST_DRAIN;
                        end else begin
                            dy <= dy + OW'(1);
                        end
                    end else begin
                        dx <= dx + OW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: one pop per item, and the unit is busy right after taking it
    assert_busy_after_pop_R2: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> (busy && !fifo_pop));

    // R8: a busy window only ever opens because of a pop
    assert_busy_origin_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(fifo_pop));

endmodule

// File: rtl/blk_bilerp_mac.sv
module blk_bilerp_mac
    import blk_bilerp_pkg::*;
#(
    parameter int MAX_LOG = 4,
    localparam int KW     = $clog2(MAX_LOG + 1),
    localparam int OW     = MAX_LOG + 1,
    localparam int AW     = BL_PIX_W + 2 * MAX_LOG + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic [1:0]    cap_idx,
    input  pix_t          rd_data,
    input  logic [KW-1:0] k,
    input  logic [OW-1:0] dx,
    input  logic [OW-1:0] dy,
    input  logic          live,
    output pix_t          pix
);

    corner_set_t cr;
    logic [OW-1:0] n, ex, ey;
    logic [KW:0]   sh;
    logic [AW-1:0] acc, half;
    pix_t lo, hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            cr <= '0;
        end else if (cap_en) begin
            case (corner_e'(cap_idx))
                CR_TL:   cr.tl <= rd_data;
                CR_TR:   cr.tr <= rd_data;
                CR_BL:   cr.bl <= rd_data;
                default: cr.br <= rd_data;
            endcase
        end
    end

    always_comb begin
        n    = OW'(1) << k;
        ex   = n - dx;
        ey   = n - dy;
        sh   = {k, 1'b0};
        half = (AW'(1) << sh) >> 1;
        acc  = AW'(cr.tl) * AW'(ex) * AW'(ey)
             + AW'(cr.tr) * AW'(dx) * AW'(ey)
             + AW'(cr.bl) * AW'(ex) * AW'(dy)
             + AW'(cr.br) * AW'(dx) * AW'(dy);
        pix  = BL_PIX_W'((acc + half) >> sh);
    end

    always_comb begin
        lo = cr.tl;
        hi = cr.tl;
        if (cr.tr < lo) lo = cr.tr;
        if (cr.bl < lo) lo = cr.bl;
        if (cr.br < lo) lo = cr.br;
        if (cr.tr > hi) hi = cr.tr;
        if (cr.bl > hi) hi = cr.bl;
        if (cr.br > hi) hi = cr.br;
    end

    // R4: a weighted blend never leaves the corner value range
    assert_convex_R4: assert property (@(posedge clk) disable iff (rst)
        live |-> ((pix >= lo) && (pix <= hi)));

endmodule

// File: rtl/blk_bilerp.sv
module blk_bilerp
    import blk_bilerp_pkg::*;
#(
    parameter int DIM     = 17,
    parameter int MAX_LOG = 4,
    localparam int COORD_W = $clog2(DIM),
    localparam int ADDR_W  = $clog2(DIM * DIM),
    localparam int KW      = $clog2(MAX_LOG + 1),
    localparam int OW      = MAX_LOG + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    input  logic [COORD_W-1:0] desc_ax,
    input  logic [COORD_W-1:0] desc_ay,
    input  logic [KW-1:0]     desc_k,
    input  logic              trim_far,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BL_PIX_W-1:0] rd_data,
    input  logic              rd_smp,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BL_PIX_W-1:0] wr_data,
    output logic              busy
);

    logic              cap_en, s_v, s_keep;
    logic [1:0]        cap_idx;
    logic [OW-1:0]     s_dx, s_dy;
    logic [ADDR_W-1:0] s_addr;
    logic [KW-1:0]     k_q;
    pix_t              pix;

    blk_bilerp_ctrl #(.DIM(DIM), .MAX_LOG(MAX_LOG)) u_ctrl (
        .clk(clk), .rst(rst),
        .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .desc_ax(desc_ax), .desc_ay(desc_ay), .desc_k(desc_k),
        .trim_far(trim_far), .busy(busy),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .cap_en(cap_en), .cap_idx(cap_idx),
        .s_v(s_v), .s_dx(s_dx), .s_dy(s_dy),
        .s_addr(s_addr), .s_keep(s_keep), .k_q(k_q)
    );

    blk_bilerp_mac #(.MAX_LOG(MAX_LOG)) u_mac (
        .clk(clk), .rst(rst),
        .cap_en(cap_en), .cap_idx(cap_idx), .rd_data(rd_data),
        .k(k_q), .dx(s_dx), .dy(s_dy), .live(s_v), .pix(pix)
    );

    assign wr_en   = s_v && s_keep && !rd_smp;
    assign wr_addr = s_addr;
    assign wr_data = pix;

    // R8: writes only inside a busy window
    assert_write_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    // R9: every write lands on the canvas
    assert_addr_range_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < DIM * DIM));

endmodule

// File: tb/sim_blk_bilerp.sv
module sim_blk_bilerp;

    localparam int DIM   = 17;
    localparam int CELLS = DIM * DIM;

    logic       clk = 1'b0;
    logic       rst;
    logic       fifo_empty, fifo_pop, trim_far;
    logic [4:0] desc_ax, desc_ay;
    logic [2:0] desc_k;
    logic       rd_en, rd_smp, wr_en, busy;
    logic [8:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;

    always #5 clk = ~clk;

    // canvas held by the bench
    logic [7:0] cv [0:CELLS-1];
    bit         sm [0:CELLS-1];
    int         md [0:CELLS-1];
    int         wcnt = 0;
    logic       tb_we = 1'b0;
    logic [8:0] tb_wa = '0;
    logic [7:0] tb_wd = '0;

    // work queue
    logic [4:0] qx [0:63];
    logic [4:0] qy [0:63];
    logic [2:0] qk [0:63];
    bit         qt [0:63];
    int head = 0;
    int tail = 0;
    int bad_pop = 0;

    assign fifo_empty = (head == tail);
    assign desc_ax    = qx[head % 64];
    assign desc_ay    = qy[head % 64];
    assign desc_k     = qk[head % 64];
    assign trim_far   = qt[head % 64];

    always @(posedge clk) begin
        if (int'(rd_addr) < CELLS) begin
            rd_data <= cv[rd_addr];
            rd_smp  <= sm[rd_addr];
        end else begin
            rd_data <= '0;
            rd_smp  <= 1'b0;
        end
        if (wr_en) begin
            cv[wr_addr] <= wr_data;
            wcnt <= wcnt + 1;
        end else if (tb_we) begin
            cv[tb_wa] <= tb_wd;
        end
        if (fifo_pop) head <= head + 1;
    end

    always @(negedge clk) if (fifo_pop && fifo_empty) bad_pop <= bad_pop + 1;

    blk_bilerp u0 (
        .clk(clk), .rst(rst),
        .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .desc_ax(desc_ax), .desc_ay(desc_ay), .desc_k(desc_k),
        .trim_far(trim_far),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_smp(rd_smp),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_px(int tl, int tr, int bl, int br, int k, int dx, int dy);
        int n, s, num;
        n = 1 << k;
        s = n * n;
        num = tl * (n - dx) * (n - dy) + tr * dx * (n - dy)
            + bl * (n - dx) * dy + br * dx * dy;
        return (num + s / 2) / s;
    endfunction

    // mode 0: random values, 1: flat value, sampled density given as 1 in dens
    task automatic load_canvas(int mode, int dens);
        for (int a = 0; a < CELLS; a++) begin
            @(negedge clk);
            tb_we = 1'b1;
            tb_wa = 9'(a);
            tb_wd = (mode == 1) ? 8'd77 : 8'($urandom);
            md[a] = int'(tb_wd);
            sm[a] = (dens == 0) ? 1'b0 : (dens == 1) ? 1'b1 : (($urandom % dens) == 0);
        end
        @(negedge clk);
        tb_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic model_block(int ax, int ay, int k, bit tr, inout int nw);
        int n, tl, trr, bl, br, a;
        n = 1 << k;
        tl = md[ay * DIM + ax];
        trr = md[ay * DIM + ax + n];
        bl = md[(ay + n) * DIM + ax];
        br = md[(ay + n) * DIM + ax + n];
        for (int dy = 0; dy <= n; dy++) begin
            for (int dx = 0; dx <= n; dx++) begin
                a = (ay + dy) * DIM + ax + dx;
                if ((dx == 0 || dx == n) && (dy == 0 || dy == n)) continue;
                if (tr && (dx == n || dy == n)) continue;
                if (sm[a]) continue;
                md[a] = ref_px(tl, trr, bl, br, k, dx, dy);
                nw++;
            end
        end
    endtask

    task automatic enqueue(int ax, int ay, int k, bit tr);
        @(negedge clk);
        qx[tail % 64] = 5'(ax);
        qy[tail % 64] = 5'(ay);
        qk[tail % 64] = 3'(k);
        qt[tail % 64] = tr;
        tail++;
    endtask

    task automatic run_one(int ax, int ay, int k, bit tr);
        int n, w0, nw, cyc, waitc;
        int ra [4];
        int ea [4];
        int e_smp, e_cor, e_trm, e_out, e_fil, dx, dy;
        n = 1 << k;
        w0 = wcnt;
        nw = 0;
        enqueue(ax, ay, k, tr);
        waitc = 0;
        @(negedge clk);
        while (!busy && waitc < 10) begin
            waitc++;
            @(negedge clk);
        end
        cyc = 0;
        while (busy && cyc < 2000) begin
            if (cyc < 4) ra[cyc] = int'(rd_addr);
            cyc++;
            @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
        ea[0] = ay * DIM + ax;
        ea[1] = ay * DIM + ax + n;
        ea[2] = (ay + n) * DIM + ax;
        ea[3] = (ay + n) * DIM + ax + n;
        for (int i = 0; i < 4; i++) chk(ra[i] == ea[i], "R3", "corner read address", ra[i], ea[i]);
        chk(cyc == 5 + (n + 1) * (n + 1), "R8", "busy cycle count", cyc, 5 + (n + 1) * (n + 1));
        model_block(ax, ay, k, tr, nw);
        chk((wcnt - w0) == nw, "R5", "number of writes", wcnt - w0, nw);
        e_smp = 0; e_cor = 0; e_trm = 0; e_out = 0; e_fil = 0;
        for (int y = 0; y < DIM; y++) begin
            for (int x = 0; x < DIM; x++) begin
                int a;
                a = y * DIM + x;
                if (int'(cv[a]) == md[a]) continue;
                dx = x - ax;
                dy = y - ay;
                if (dx < 0 || dy < 0 || dx > n || dy > n) e_out++;
                else if ((dx == 0 || dx == n) && (dy == 0 || dy == n)) e_cor++;
                else if (tr && (dx == n || dy == n)) e_trm++;
                else if (sm[a]) e_smp++;
                else e_fil++;
            end
        end
        chk(e_fil == 0, "R4", "filled pixel mismatches", e_fil, 0);
        chk(e_smp == 0, "R5", "sampled pixels changed", e_smp, 0);
        chk(e_cor == 0, "R6", "corner pixels changed", e_cor, 0);
        chk(e_trm == 0, "R7", "trimmed edge pixels changed", e_trm, 0);
        chk(e_out == 0, "R9", "pixels outside region changed", e_out, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = int'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            qx[i] = '0; qy[i] = '0; qk[i] = '0; qt[i] = 1'b0;
        end
        for (int a = 0; a < CELLS; a++) begin
            cv[a] = '0; sm[a] = 1'b0; md[a] = 0;
        end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(fifo_pop == 1'b0 && rd_en == 1'b0 && wr_en == 1'b0, "R1", "strobes in reset",
            int'({fifo_pop, rd_en, wr_en}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && rd_en == 1'b0, "R1", "idle after reset", int'({busy, rd_en}), 0);

        // directed: full block, nothing sampled, edges kept (R7 off)
        load_canvas(0, 0);
        run_one(0, 0, 4, 1'b0);
        // directed: full block with trimmed far edges (R7)
        load_canvas(0, 0);
        run_one(0, 0, 4, 1'b1);
        // directed: smallest region
        load_canvas(0, 3);
        run_one(13, 7, 1, 1'b0);
        // directed: all sampled, no write expected (R5)
        load_canvas(0, 1);
        run_one(4, 4, 3, 1'b0);
        // directed: flat corners give flat fill (R4)
        load_canvas(1, 0);
        run_one(8, 8, 3, 1'b0);

        // random regions
        for (int t = 0; t < 16; t++) begin
            int k, n;
            k = 1 + int'($urandom % 4);
            n = 1 << k;
            load_canvas(0, 4);
            run_one(int'($urandom % (DIM - n)), int'($urandom % (DIM - n)), k, 1'($urandom));
        end

        // R2: three items queued back to back, processed in order
        begin
            int w0, nw, waitc, mism;
            load_canvas(0, 5);
            w0 = wcnt;
            nw = 0;
            enqueue(0, 0, 3, 1'b0);
            enqueue(4, 4, 3, 1'b0);
            enqueue(6, 2, 2, 1'b1);
            waitc = 0;
            while ((!fifo_empty || busy) && waitc < 2000) begin
                waitc++;
                @(negedge clk);
            end
            repeat (3) @(negedge clk);
            model_block(0, 0, 3, 1'b0, nw);
            model_block(4, 4, 3, 1'b0, nw);
            model_block(6, 2, 2, 1'b1, nw);
            mism = 0;
            for (int a = 0; a < CELLS; a++) if (int'(cv[a]) != md[a]) mism++;
            chk(mism == 0, "R2", "in-order queue result mismatches", mism, 0);
            chk((wcnt - w0) == nw, "R2", "writes over queued items", wcnt - w0, nw);
            chk(head == tail, "R2", "items taken", head, tail);
        end
        chk(bad_pop == 0, "R2", "pops while queue empty", bad_pop, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule